// File: doc/BRIEF.md
# PCI Configuration Access Translator

This block turns configuration-space requests from a host into dword-sized bus cycles for a PCI bridge window. A request names a bus number, device, function, register offset, access size (1, 2 or 4 bytes), a direction flag and write data. The block checks that the request is legal and builds the configuration address. Requests to bus 0 use a one-hot device-select encoding. Requests to other buses use a packed bus/device/function encoding. A mode output tells the window logic which of the two encodings is in use.

The bus side takes one dword access at a time. The block aligns read data down to the low byte lanes. It handles byte and halfword writes by reading the dword, merging the new lanes and writing the dword back. Illegal requests get an error response and never reach the bus. A bus error also gives an error response, and on a read it gives all-ones data.

Top module: `pci_cfg_xlate`

## Requirements
- R1: A legal request with bus number 0 drives `bus_type1` low and a bus address that has exactly one of bits 31:16 set, at bit (device + 16). The function is in bits 10:8, offset bits 7:2 are in address bits 7:2, and address bits 1:0 are zero.
- R2: A legal request with a non-zero bus number drives `bus_type1` high and a bus address with the bus in bits 23:16, the device in bits 15:11, the function in bits 10:8, offset bits 7:2 in bits 7:2, and all other bits zero.
- R3: A request on bus 0 with a device number of 16 or more is rejected. `rsp_valid` and `rsp_err` are high in the cycle after acceptance, and `bus_req` never rises for it.
- R4: While `card_mode` is high, a request with a device number above 1 is rejected on any bus in the same way as R3. Devices 0 and 1 are still accepted.
- R5: A request whose size is not 1, 2 or 4 is rejected in the same way as R3.
- R6: A successful read returns the bus dword shifted right by 8 × (offset mod 4). The result is then cut to the low 8 bits for size 1 or the low 16 bits for size 2, with the upper bits zero. Size 4 keeps all 32 bits.
- R7: A 1- or 2-byte write issues a dword read and then a dword write to the same address. The written dword is the read dword with the byte or halfword at shift 8 × (offset mod 4) replaced by the low write data. Lanes above bit 31 are dropped.
- R8: A 4-byte write issues exactly one bus write carrying `req_wdata` unchanged, with no read.
- R9: If `bus_err` is high with `bus_done` on a read, the response has `rsp_err` high and `rsp_rdata` equal to 0xFFFFFFFF, and a pending merge write is abandoned. A bus error on a write gives `rsp_err` high. Successful writes respond with `rsp_err` low and zero data.
- R10: `req_ready` is low from acceptance until the response. While `bus_req` is high and `bus_done` is low, `bus_addr`, `bus_we`, `bus_wdata` and `bus_type1` do not change.
- R11: After reset, `req_ready` is high and `bus_req` and `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| card_mode | input | 1 | Restricts legal device numbers to 0 and 1 |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_func | input | 3 | Function number |
| req_off | input | 8 | Register byte offset |
| req_size | input | 3 | Access size in bytes (1, 2, 4 legal) |
| req_wdata | input | 32 | Write data, low-lane justified |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Request rejected or bus error |
| rsp_rdata | output | 32 | Aligned read data |
| bus_req | output | 1 | Dword access pending |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | 32 | Configuration address |
| bus_wdata | output | 32 | Dword write data |
| bus_type1 | output | 1 | Window mode: 0 = one-hot select, 1 = packed encoding |
| bus_done | input | 1 | Access complete strobe |
| bus_rdata | input | 32 | Read dword, valid with bus_done |
| bus_err | input | 1 | Access failed, valid with bus_done |

## Verification
The bench goes after the legality edges: device 15 against 16 on bus 0, device 1 against 2 in card mode, and sizes 0, 3 and 5 to 7. A design that gets one wrong would either start a bus cycle for a bad request or refuse a good one. It drives halfword accesses at offset 3, where part of the lane falls off the dword. A wrong shift or mask there would corrupt neighbouring bytes in the written-back dword, or leak high bytes into read data. It also injects errors on the first read of a merge write. A design that kept going would write back a dword built from all-ones or stale data instead of abandoning the write.

// File: rtl/pci_cfg_pkg.sv
// Shared types and constants for the configuration access translator.
// Assumes a 32-bit dword bus and the fixed field positions of the
// configuration address formats.
package pci_cfg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2,
        ST_RESP = 2'd3
    } seq_state_t;

    localparam int SEL_LSB  = 16;
    localparam int BUS_LSB  = 16;
    localparam int DEV_LSB  = 11;
    localparam int FUNC_LSB = 8;
endpackage

// File: rtl/cfg_addr_gen.sv
// Checks a request for legality and forms the configuration address.
// Purely combinational. Assumes the one-hot select field fits above
// bit 15 of the address (SEL_LSB + SLOT_MAX <= ADDR_W).
module cfg_addr_gen
    import pci_cfg_pkg::*;
#(
    parameter int BUS_W    = 8,
    parameter int DEV_W    = 5,
    parameter int FUNC_W   = 3,
    parameter int OFF_W    = 8,
    parameter int SIZE_W   = 3,
    parameter int ADDR_W   = 32,
    parameter int SLOT_MAX = 16
) (
    input  logic [BUS_W-1:0]  bus_num,
    input  logic [DEV_W-1:0]  dev_num,
    input  logic [FUNC_W-1:0] func_num,
    input  logic [OFF_W-1:2]  off_dw,
    input  logic [SIZE_W-1:0] size,
    input  logic              card_mode,
    output logic [ADDR_W-1:0] addr,
    output logic              type1,
    output logic              legal
);
    logic [SLOT_MAX-1:0] sel_onehot;
    logic [ADDR_W-1:0]   addr_t0;
    logic [ADDR_W-1:0]   addr_t1;
    logic                size_ok;
    logic                card_bad;
    logic                slot_bad;

    // one-hot device select, one decoder per slot
    for (genvar g = 0; g < SLOT_MAX; g++) begin : g_sel
        assign sel_onehot[g] = (dev_num == DEV_W'(g));
    end

    // address for same-bus (one-hot select) cycles
    always_comb begin
        addr_t0 = '0;
        addr_t0[SEL_LSB +: SLOT_MAX]  = sel_onehot;
        addr_t0[FUNC_LSB +: FUNC_W]   = func_num;
        addr_t0[OFF_W-1:2]            = off_dw;
    end

    // address for downstream-bus (packed) cycles
    always_comb begin
        addr_t1 = '0;
        addr_t1[BUS_LSB +: BUS_W]   = bus_num;
        addr_t1[DEV_LSB +: DEV_W]   = dev_num;
        addr_t1[FUNC_LSB +: FUNC_W] = func_num;
        addr_t1[OFF_W-1:2]          = off_dw;
    end

    // legality checks and format selection
    always_comb begin
        type1    = (bus_num != '0);
        size_ok  = (size == SIZE_W'(1)) || (size == SIZE_W'(2)) || (size == SIZE_W'(4));
        card_bad = card_mode && (dev_num > DEV_W'(1));
        slot_bad = !type1 && (dev_num >= DEV_W'(SLOT_MAX));
        legal    = size_ok && !card_bad && !slot_bad;
        addr     = type1 ? addr_t1 : addr_t0;
    end
endmodule

// File: rtl/cfg_lane_unit.sv
// Byte-lane handling: aligns read dwords to the low lanes and merges
// sub-dword write data into a previously read dword.
// Combinational. Assumes size is 1, 2 or 4 once the request is legal.
module cfg_lane_unit #(
    parameter int DATA_W = 32,
    parameter int SIZE_W = 3,
    localparam int LANES  = DATA_W / 8,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic [LANE_W-1:0] lo,
    input  logic [SIZE_W-1:0] size,
    input  logic [DATA_W-1:0] rd_raw,
    input  logic [DATA_W-1:0] old_dword,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_aligned,
    output logic [DATA_W-1:0] merged
);
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] keep_mask;
    logic [DATA_W-1:0] lane_mix;

    // read alignment: shift down then cut to the access size
    always_comb begin
        shifted = rd_raw >> {lo, 3'b000};
        if (size == SIZE_W'(1))
            keep_mask = DATA_W'(8'hFF);
        else if (size == SIZE_W'(2))
            keep_mask = DATA_W'(16'hFFFF);
        else
            keep_mask = '1;
        rd_aligned = shifted & keep_mask;
    end

    // per-lane merge of new bytes into the old dword
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [LANE_W-1:0] rel;
        logic              hit;
        assign rel = LANE_W'(j) - lo;
        assign hit = (LANE_W'(j) >= lo) && (SIZE_W'(rel) < size);
        assign lane_mix[8*j +: 8] = hit ? wdata[8*rel +: 8] : old_dword[8*j +: 8];
    end

    // full-dword writes bypass the merge
    always_comb begin
        merged = (size == SIZE_W'(LANES)) ? wdata : lane_mix;
    end
endmodule

// File: rtl/cfg_seq.sv
// Request sequencer: accepts one request at a time, runs the read,
// write or read-then-write bus sequence, and issues the response.
// Assumes the bus side answers each access with a single bus_done.
module cfg_seq
    import pci_cfg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 3,
    localparam int LANES  = DATA_W / 8,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [LANE_W-1:0] req_lo,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              chk_legal,
    input  logic [ADDR_W-1:0] chk_addr,
    input  logic              chk_type1,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_type1,
    input  logic              bus_done,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_err
);
    seq_state_t        state;
    logic [LANE_W-1:0] lat_lo;
    logic [SIZE_W-1:0] lat_size;
    logic              lat_we;
    logic [DATA_W-1:0] lat_wdata;
    logic [DATA_W-1:0] hold_dword;
    logic [DATA_W-1:0] rd_aligned;
    logic [DATA_W-1:0] merged;
    logic              accept;

    cfg_lane_unit #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_lane (
        .lo         (lat_lo),
        .size       (lat_size),
        .rd_raw     (bus_rdata),
        .old_dword  (hold_dword),
        .wdata      (lat_wdata),
        .rd_aligned (rd_aligned),
        .merged     (merged)
    );

    assign accept    = req_valid && (state == ST_IDLE);
    assign req_ready = (state == ST_IDLE);
    assign rsp_valid = (state == ST_RESP);
    assign bus_req   = (state == ST_RD) || (state == ST_WR);
    assign bus_we    = (state == ST_WR);
    assign bus_wdata = merged;

    // state machine and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            lat_lo     <= '0;
            lat_size   <= '0;
            lat_we     <= 1'b0;
            lat_wdata  <= '0;
            hold_dword <= '0;
            bus_addr   <= '0;
            bus_type1  <= 1'b0;
            rsp_err    <= 1'b0;
            rsp_rdata  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    lat_lo    <= req_lo;
                    lat_size  <= req_size;
                    lat_we    <= req_write;
                    lat_wdata <= req_wdata;
                    bus_addr  <= chk_addr;
                    bus_type1 <= chk_type1;
                    rsp_rdata <= '0;
                    rsp_err   <= 1'b0;
                    if (!chk_legal) begin
                        rsp_err <= 1'b1;
                        state   <= ST_RESP;
                    end else if (req_write && (req_size == SIZE_W'(LANES))) begin
                        state <= ST_WR;
                    end else begin
                        state <= ST_RD;
                    end
                end
                ST_RD: if (bus_done) begin
                    if (bus_err) begin
                        rsp_err   <= 1'b1;
                        rsp_rdata <= '1;
                        state     <= ST_RESP;
                    end else if (lat_we) begin
                        hold_dword <= bus_rdata;
                        state      <= ST_WR;
                    end else begin
                        rsp_rdata <= rd_aligned;
                        state     <= ST_RESP;
                    end
                end
                ST_WR: if (bus_done) begin
                    rsp_err <= bus_err;
                    state   <= ST_RESP;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R10: bus side held steady until completion
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_done) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                                    && $stable(bus_wdata) && $stable(bus_type1)));
    // R10: no new request while busy
    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !req_ready);
    // R3: rejected requests answer next cycle without a bus access
    p_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !chk_legal) |=> (rsp_valid && rsp_err && !bus_req));
    // R8: full-dword writes go straight to a write
    p_direct_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && chk_legal && req_write && req_size == SIZE_W'(LANES)) |=> (bus_req && bus_we));
    // R7: partial writes start with a read
    p_rmw_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && chk_legal && req_write && req_size != SIZE_W'(LANES)) |=> (bus_req && !bus_we));
    // R9: read error yields all ones and an error
    p_rderr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_done && bus_err) |=> (rsp_valid && rsp_err && rsp_rdata == '1));
    // R1: same-bus cycles carry exactly one select bit
    p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_type1) |-> $onehot(bus_addr[ADDR_W-1:SEL_LSB]));
    // R2: addresses are always dword aligned
    p_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_addr[1:0] == 2'b00));
endmodule

// File: rtl/pci_cfg_xlate.sv
// Top of the configuration access translator: legality and address
// generation feeding a single-outstanding request sequencer.
// Assumes the host holds request fields stable while req_valid is high.
module pci_cfg_xlate #(
    parameter int BUS_W    = 8,
    parameter int DEV_W    = 5,
    parameter int FUNC_W   = 3,
    parameter int OFF_W    = 8,
    parameter int SIZE_W   = 3,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 32,
    parameter int SLOT_MAX = 16,
    localparam int LANE_W  = $clog2(DATA_W / 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              card_mode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BUS_W-1:0]  req_bus,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [FUNC_W-1:0] req_func,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_type1,
    input  logic              bus_done,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_err
);
    logic              chk_legal;
    logic              chk_type1;
    logic [ADDR_W-1:0] chk_addr;

    cfg_addr_gen #(
        .BUS_W(BUS_W), .DEV_W(DEV_W), .FUNC_W(FUNC_W), .OFF_W(OFF_W),
        .SIZE_W(SIZE_W), .ADDR_W(ADDR_W), .SLOT_MAX(SLOT_MAX)
    ) u_addr (
        .bus_num   (req_bus),
        .dev_num   (req_dev),
        .func_num  (req_func),
        .off_dw    (req_off[OFF_W-1:2]),
        .size      (req_size),
        .card_mode (card_mode),
        .addr      (chk_addr),
        .type1     (chk_type1),
        .legal     (chk_legal)
    );

    cfg_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_lo    (req_off[LANE_W-1:0]),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .chk_legal (chk_legal),
        .chk_addr  (chk_addr),
        .chk_type1 (chk_type1),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_type1 (bus_type1),
        .bus_done  (bus_done),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err)
    );
endmodule

// File: tb/pci_cfg_xlate_test.sv
module pci_cfg_xlate_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        card_mode = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [4:0]  req_dev = '0;
    logic [2:0]  req_func = '0;
    logic [7:0]  req_off = '0;
    logic [2:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        bus_req, bus_we, bus_type1;
    logic [31:0] bus_addr, bus_wdata;
    logic        bus_done = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        bus_err = 1'b0;

    int checks = 0;
    int failures = 0;
    logic        inject_rd_err = 1'b0;
    int          lat_sel = 0;
    int          log_n = 0;
    logic [31:0] log_addr [4];
    logic [31:0] log_wd [4];
    logic        log_we [4];
    logic        log_t1 [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    pci_cfg_xlate uut (
        .clk(clk), .rst_n(rst_n), .card_mode(card_mode),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func),
        .req_off(req_off), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_type1(bus_type1),
        .bus_done(bus_done), .bus_rdata(bus_rdata), .bus_err(bus_err)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5BD1E995;
    endfunction

    // bus model: answers each access after a short, varying delay
    int wait_cnt = 0;
    always @(negedge clk) begin
        if (bus_done) begin
            bus_done <= 1'b0;
            bus_err  <= 1'b0;
            wait_cnt <= lat_sel % 3;
            lat_sel  <= lat_sel + 1;
        end else if (bus_req) begin
            if (wait_cnt == 0) begin
                bus_done  <= 1'b1;
                bus_rdata <= mem_word(bus_addr);
                bus_err   <= inject_rd_err && !bus_we;
                if (log_n < 4) begin
                    log_addr[log_n] = bus_addr;
                    log_wd[log_n]   = bus_wdata;
                    log_we[log_n]   = bus_we;
                    log_t1[log_n]   = bus_type1;
                end
                log_n = log_n + 1;
            end else begin
                wait_cnt <= wait_cnt - 1;
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_req(input logic w, input logic [7:0] b, input logic [4:0] d,
                           input logic [2:0] f, input logic [7:0] o, input logic [2:0] s,
                           input logic [31:0] wd, input logic cm, input logic inj);
        int n;
        logic legal, busy_bad, type1;
        logic [31:0] a, old, m, exp_rd, exp_wd;
        string rej_tag;
        @(negedge clk);
        log_n = 0;
        inject_rd_err = inj;
        card_mode = cm; req_write = w; req_bus = b; req_dev = d; req_func = f;
        req_off = o; req_size = s; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        busy_bad = 1'b0;
        while (!rsp_valid && n < 60) begin
            if (req_ready) busy_bad = 1'b1;
            @(negedge clk);
            n++;
        end
        chk(n < 60, "R10 response timeout", n, 60);
        chk(!busy_bad, "R10 ready low while busy", busy_bad, 0);
        legal = (s == 1 || s == 2 || s == 4) && !(cm && d > 1) && !(b == 0 && d >= 16);
        rej_tag = !(s == 1 || s == 2 || s == 4) ? "R5" : (cm && d > 1) ? "R4" : "R3";
        if (!legal) begin
            chk(n == 0, {rej_tag, " reject latency"}, n, 0);
            chk(rsp_err, {rej_tag, " reject err"}, rsp_err, 1);
            chk(log_n == 0, {rej_tag, " no bus access"}, log_n, 0);
        end else begin
            type1 = (b != 0);
            a = type1 ? ({8'h0, b, 16'h0} | (32'(d) << 11)) : (32'h1 << (d + 16));
            a = a | (32'(f) << 8) | 32'({o[7:2], 2'b00});
            old = mem_word(a);
            m = (s == 1) ? 32'hFF : (s == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
            chk(log_n >= 1, "R1/2 bus access made", log_n, 1);
            chk(log_addr[0] == a, type1 ? "R2 address" : "R1 address", log_addr[0], a);
            chk(log_t1[0] == type1, type1 ? "R2 mode" : "R1 mode", log_t1[0], type1);
            if (!w) begin
                chk(log_n == 1 && !log_we[0], "R6 single read", log_n, 1);
                exp_rd = inj ? 32'hFFFF_FFFF : ((old >> (8 * o[1:0])) & m);
                chk(rsp_err == inj, "R9 read err flag", rsp_err, inj);
                chk(rsp_rdata == exp_rd, inj ? "R9 read data" : "R6 read data", rsp_rdata, exp_rd);
            end else if (s == 4) begin
                chk(log_n == 1 && log_we[0], "R8 single write", log_n, 1);
                chk(log_wd[0] == wd, "R8 write data", log_wd[0], wd);
                chk(!rsp_err && rsp_rdata == 0, "R9 write ok response", rsp_err, 0);
            end else if (inj) begin
                chk(log_n == 1 && !log_we[0], "R9 merge abandoned", log_n, 1);
                chk(rsp_err && rsp_rdata == 32'hFFFF_FFFF, "R9 merge err response", rsp_rdata, 32'hFFFF_FFFF);
            end else begin
                exp_wd = (old & ~(m << (8 * o[1:0]))) | ((wd & m) << (8 * o[1:0]));
                chk(log_n == 2 && !log_we[0] && log_we[1], "R7 read then write", log_n, 2);
                chk(log_addr[1] == a, "R7 write address", log_addr[1], a);
                chk(log_wd[1] == exp_wd, "R7 merged data", log_wd[1], exp_wd);
                chk(!rsp_err, "R9 write ok flag", rsp_err, 0);
            end
        end
        inject_rd_err = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !bus_req && !rsp_valid, "R11 reset state", {req_ready, bus_req, rsp_valid}, 3'b100);
        // directed corners
        run_req(0, 8'd0, 5'd3,  3'd2, 8'h45, 3'd1, 32'h0, 0, 0);   // R1 byte read
        run_req(0, 8'd0, 5'd15, 3'd7, 8'hFF, 3'd2, 32'h0, 0, 0);   // R1 top slot, off 3 half
        run_req(0, 8'd0, 5'd16, 3'd0, 8'h00, 3'd4, 32'h0, 0, 0);   // R3
        run_req(0, 8'd5, 5'd31, 3'd1, 8'h10, 3'd4, 32'h0, 0, 0);   // R2
        run_req(0, 8'd1, 5'd2,  3'd0, 8'h00, 3'd4, 32'h0, 1, 0);   // R4 reject
        run_req(0, 8'd0, 5'd1,  3'd0, 8'h08, 3'd4, 32'h0, 1, 0);   // R4 accept
        run_req(0, 8'd0, 5'd1,  3'd0, 8'h08, 3'd3, 32'h0, 0, 0);   // R5
        run_req(1, 8'd0, 5'd0,  3'd0, 8'h00, 3'd0, 32'h0, 0, 0);   // R5 size 0
        run_req(1, 8'd0, 5'd4,  3'd0, 8'h0E, 3'd2, 32'hABCD1234, 0, 0); // R7
        run_req(1, 8'd2, 5'd9,  3'd3, 8'h23, 3'd2, 32'h0000BEEF, 0, 0); // R7 off 3
        run_req(1, 8'd0, 5'd6,  3'd5, 8'h41, 3'd4, 32'hCAFEF00D, 0, 0); // R8
        run_req(0, 8'd7, 5'd3,  3'd0, 8'h04, 3'd4, 32'h0, 0, 1);   // R9 read error
        run_req(1, 8'd0, 5'd2,  3'd0, 8'h05, 3'd1, 32'h77, 0, 1);  // R9 merge error
        // constrained random mix
        for (int i = 0; i < 250; i++) begin
            logic [7:0] rb;
            rb = ($urandom % 2 == 0) ? 8'd0 : 8'($urandom);
            run_req(1'($urandom), rb, 5'($urandom), 3'($urandom), 8'($urandom),
                    ($urandom % 4 == 0) ? 3'($urandom) : (($urandom % 3 == 0) ? 3'd4 : 3'(1 + $urandom % 2)),
                    $urandom, ($urandom % 4 == 0), ($urandom % 8 == 0));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule